// File: doc/BRIEF.md
# Raster Timing Chain with Serial Clock Tap

This block is the timing backbone of a small character-cell display terminal. A horizontal counter advances by one on each character-slot tick. When it reaches its terminal count it returns to zero, and the vertical line counter moves forward. When the vertical counter would roll over past all ones, the frame ends instead. The vertical counter is then preloaded with one of two start values, picked by a mains-frequency select input. This sets how many lines a frame has, so it sets the refresh rate.

The same chain also supplies the serial clocks. A square wave for the fastest serial rate is cut from fixed positions in the horizontal count. The low seven bits of the line count are exported so that logic further on can divide them down to slower rates. The block also flags the top of the screen and produces a column-address increment enable with its own 7-bit wrapping column counter. The increment is gated by an active-video input and limited to a window of horizontal positions.

A line-phase state machine tracks where the current line stands relative to the serial clock taps. There are three states. LP_LEAD covers the slots before the rise tap. LP_BAUD covers the serial clock high time. LP_TAIL covers the rest of the line. The transitions are: LP_LEAD to LP_BAUD when the count reaches BAUD_ON; LP_BAUD to LP_TAIL when it reaches BAUD_OFF, which also clears the top-of-screen flag; and any state back to LP_LEAD at end of line. All outputs are registered and update on the clock edge at which the tick is sampled.

Top module: `raster_timing_chain`

## Requirements
- R1: While reset (rst_n low) is applied, top_of_frame is 1 and baud_clk, vline_low, col_addr and col_step are all 0; the horizontal and vertical counters start from 0.
- R2: baud_clk rises on the tick that advances the horizontal count to 4 and falls on the tick that advances it to 8, so it is high for exactly four ticks of every line.
- R3: top_of_frame clears on the tick that advances the horizontal count to 8 and stays clear until the next frame end.
- R4: A line lasts LINE_LAST+1 ticks (horizontal count 0..LINE_LAST). On the tick at count LINE_LAST the horizontal count returns to 0 and the vertical count increments; vline_low then shows bits 6:0 of the new vertical count.
- R5: When the vertical count is all ones at end of line, the frame ends. The vertical count is reloaded with RELOAD_HI if freq_sel is 1 on that tick and RELOAD_LO if it is 0, vline_low is driven to 0, and top_of_frame is set. freq_sel has no effect on any other tick, so the next frame has 2^VW minus the reload value lines.
- R6: On a tick with video_en high, if the horizontal count minus 2, taken modulo 2^HW, is at least 32, col_addr increments by one (wrapping in 7 bits) and col_step is 1 for that one cycle. Otherwise col_step is 0.
- R7: In a cycle with tick low, baud_clk, top_of_frame, vline_low and col_addr hold their values and col_step is 0.
- R8: On a tick with video_en low, col_addr holds and col_step is 0, whatever the horizontal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle character-slot enable |
| freq_sel | input | 1 | Mains-frequency select: 1 picks RELOAD_HI, 0 picks RELOAD_LO |
| video_en | input | 1 | Active-video qualifier for column stepping |
| top_of_frame | output | 1 | High from frame start until horizontal count 8 of the first line |
| baud_clk | output | 1 | Fastest serial-rate square wave, high during counts 4..7 |
| vline_low | output | 7 | Low bits of the vertical count for further rate division |
| col_step | output | 1 | Pulse: column address advanced on this edge |
| col_addr | output | 7 | Wrapping column address |

## Verification
The assertions assume that tick is a one-cycle qualifier that can be low for any number of cycles, that video_en and freq_sel matter only on ticking cycles, and that LINE_LAST is at least 8, so every line passes through all three phases. The stimulus drives all inputs just after the falling edge. It holds tick low one cycle in four and switches video_en in blocks that cut across line boundaries, so the column window, including its wrap at counts 0 and 1, is exercised both gated and ungated. freq_sel toggles in the middle of frames. The line count of each frame is measured from baud_clk rises between top_of_frame rises and compared with the reload value that was selected at the preceding frame end.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        LP_LEAD = 2'd0,
        LP_BAUD = 2'd1,
        LP_TAIL = 2'd2
    } line_phase_e;

endpackage

// File: rtl/rtc_hcounter.sv
module rtc_hcounter #(
    parameter int LINE_LAST = 160,
    parameter int HW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [HW-1:0] hcount,
    output logic          eol
);
    localparam logic [HW-1:0] H_TERM = HW'(LINE_LAST);

    assign eol = tick && (hcount == H_TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcount <= '0;
        end else if (tick) begin
            if (hcount == H_TERM) hcount <= '0;
            else                  hcount <= hcount + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_vcounter.sv
module rtc_vcounter #(
    parameter int VW        = 12,
    parameter int OUT_W     = 7,
    parameter int RELOAD_HI = 1536,
    parameter int RELOAD_LO = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eol,
    input  logic             freq_sel,
    output logic             frame_end,
    output logic [OUT_W-1:0] vline_low
);
    localparam logic [VW-1:0] V_MAX  = '1;
    localparam logic [VW-1:0] PRE_HI = VW'(RELOAD_HI);
    localparam logic [VW-1:0] PRE_LO = VW'(RELOAD_LO);

    logic [VW-1:0] vcount;
    logic [VW-1:0] v_next;

    assign v_next    = vcount + 1'b1;
    assign frame_end = eol && (vcount == V_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcount    <= '0;
            vline_low <= '0;
        end else if (frame_end) begin
            vcount    <= freq_sel ? PRE_HI : PRE_LO;
            vline_low <= '0;
        end else if (eol) begin
            vcount    <= v_next;
            vline_low <= v_next[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/rtc_line_fsm.sv
module rtc_line_fsm
    import rtc_pkg::*;
#(
    parameter int HW       = 8,
    parameter int BAUD_ON  = 4,
    parameter int BAUD_OFF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          eol,
    input  logic          frame_end,
    input  logic [HW-1:0] hcount,
    output logic          baud_clk,
    output logic          top_of_frame
);
    localparam logic [HW-1:0] TAP_ON  = HW'(BAUD_ON);
    localparam logic [HW-1:0] TAP_OFF = HW'(BAUD_OFF);

    line_phase_e phase, phase_nxt;
    logic [HW-1:0] h_next;
    logic          adv;

    assign h_next = hcount + 1'b1;
    assign adv    = tick && !eol;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            LP_LEAD: if (eol)                        phase_nxt = LP_LEAD;
                     else if (adv && h_next == TAP_ON)  phase_nxt = LP_BAUD;
            LP_BAUD: if (eol)                        phase_nxt = LP_LEAD;
                     else if (adv && h_next == TAP_OFF) phase_nxt = LP_TAIL;
            LP_TAIL: if (eol)                        phase_nxt = LP_LEAD;
            default:                                 phase_nxt = LP_LEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= LP_LEAD;
        else        phase <= phase_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_clk     <= 1'b0;
            top_of_frame <= 1'b1;
        end else begin
            baud_clk <= (phase_nxt == LP_BAUD);
            if (frame_end)
                top_of_frame <= 1'b1;
            else if (phase == LP_BAUD && phase_nxt == LP_TAIL)
                top_of_frame <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_column.sv
module rtc_column #(
    parameter int HW        = 8,
    parameter int CW        = 7,
    parameter int COL_SKEW  = 2,
    parameter int COL_START = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          video_en,
    input  logic [HW-1:0] hcount,
    output logic [CW-1:0] col_addr,
    output logic          col_step
);
    localparam logic [HW-1:0] SKEW  = HW'(COL_SKEW);
    localparam logic [HW-1:0] START = HW'(COL_START);

    logic [HW-1:0] h_rel;
    logic          step;

    assign h_rel = hcount - SKEW;
    assign step  = tick && video_en && (h_rel >= START);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_addr <= '0;
            col_step <= 1'b0;
        end else begin
            col_step <= step;
            if (step) col_addr <= col_addr + 1'b1;
        end
    end
endmodule

// File: rtl/raster_timing_chain.sv
module raster_timing_chain #(
    parameter int LINE_LAST = 160,
    parameter int VW        = 12,
    parameter int RELOAD_HI = 1536,
    parameter int RELOAD_LO = 1024,
    parameter int BAUD_ON   = 4,
    parameter int BAUD_OFF  = 8,
    parameter int COL_SKEW  = 2,
    parameter int COL_START = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       freq_sel,
    input  logic       video_en,
    output logic       top_of_frame,
    output logic       baud_clk,
    output logic [6:0] vline_low,
    output logic       col_step,
    output logic [6:0] col_addr
);
    localparam int HW    = $clog2(LINE_LAST + 1);
    localparam int OUT_W = 7;
    localparam int CW    = 7;

    logic [HW-1:0] hcount;
    logic          eol;
    logic          frame_end;

    rtc_hcounter #(.LINE_LAST(LINE_LAST), .HW(HW)) u_h (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hcount(hcount), .eol(eol)
    );

    rtc_vcounter #(
        .VW(VW), .OUT_W(OUT_W), .RELOAD_HI(RELOAD_HI), .RELOAD_LO(RELOAD_LO)
    ) u_v (
        .clk(clk), .rst_n(rst_n), .eol(eol), .freq_sel(freq_sel),
        .frame_end(frame_end), .vline_low(vline_low)
    );

    rtc_line_fsm #(.HW(HW), .BAUD_ON(BAUD_ON), .BAUD_OFF(BAUD_OFF)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .eol(eol), .frame_end(frame_end),
        .hcount(hcount), .baud_clk(baud_clk), .top_of_frame(top_of_frame)
    );

    rtc_column #(.HW(HW), .CW(CW), .COL_SKEW(COL_SKEW), .COL_START(COL_START)) u_col (
        .clk(clk), .rst_n(rst_n), .tick(tick), .video_en(video_en),
        .hcount(hcount), .col_addr(col_addr), .col_step(col_step)
    );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       video_en,
    input logic       top_of_frame,
    input logic       baud_clk,
    input logic [6:0] vline_low,
    input logic       col_step,
    input logic [6:0] col_addr
);
    assert_baud_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(baud_clk) |-> $past(tick));

    assert_top_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_of_frame) |-> $fell(baud_clk));

    assert_reload_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_of_frame) |-> (vline_low == 7'd0));

    assert_col_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_step |-> (col_addr == 7'($past(col_addr) + 7'd1)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(baud_clk) && $stable(top_of_frame) &&
                   $stable(vline_low) && $stable(col_addr) && !col_step));

    assert_video_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col_step |-> $past(video_en));
endmodule

bind raster_timing_chain rtc_checker u_rtc_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .video_en(video_en),
    .top_of_frame(top_of_frame), .baud_clk(baud_clk), .vline_low(vline_low),
    .col_step(col_step), .col_addr(col_addr)
);

// File: tb/tb_raster_timing_chain.sv
`timescale 1ns/1ps
module tb_raster_timing_chain;
    localparam int LAST = 160;
    localparam int VWB  = 8;
    localparam int RHI  = 224;
    localparam int RLO  = 192;

    logic clk = 1'b0;
    logic rst_n, tick, freq_sel, video_en;
    logic top_of_frame, baud_clk, col_step;
    logic [6:0] vline_low, col_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    raster_timing_chain #(
        .LINE_LAST(LAST), .VW(VWB), .RELOAD_HI(RHI), .RELOAD_LO(RLO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .freq_sel(freq_sel),
        .video_en(video_en), .top_of_frame(top_of_frame), .baud_clk(baud_clk),
        .vline_low(vline_low), .col_step(col_step), .col_addr(col_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_reset();
        chk("R1 top", int'(top_of_frame), 1);
        chk("R1 baud", int'(baud_clk), 0);
        chk("R1 vline", int'(vline_low), 0);
        chk("R1 col", int'(col_addr), 0);
        chk("R1 step", int'(col_step), 0);
    endtask

    // reference model state
    int mh, mv, mvl, mcol;
    bit mtop, mbaud, mstep, reloaded, last_tick, last_ven, last_fs, prev_top;
    int baud_rises, prev_reload, frames;

    initial begin
        rst_n = 1'b0; tick = 1'b0; freq_sel = 1'b0; video_en = 1'b0;
        repeat (3) @(negedge clk);
        chk_reset();
        rst_n = 1'b1;
        mh = 0; mv = 0; mvl = 0; mcol = 0;
        mtop = 1; mbaud = 0; mstep = 0; reloaded = 0;
        last_tick = 1; last_ven = 0; last_fs = 0; prev_top = 1;
        baud_rises = 0; prev_reload = 0; frames = 0;
        for (int cyc = 0; cyc < 170000 && frames < 5; cyc++) begin
            if (cyc > 0) begin
                chk(last_tick ? "R2 baud" : "R7 baud", int'(baud_clk), int'(mbaud));
                chk(last_tick ? "R3 top" : "R7 top", int'(top_of_frame), int'(mtop));
                chk(!last_tick ? "R7 vline" : (reloaded ? "R5 vline" : "R4 vline"),
                    int'(vline_low), mvl);
                chk(!last_tick ? "R7 col" : (last_ven ? "R6 col" : "R8 col"),
                    int'(col_addr), mcol);
                chk(!last_tick ? "R7 step" : (last_ven ? "R6 step" : "R8 step"),
                    int'(col_step), int'(mstep));
                if (baud_clk && !mbaud) baud_rises = baud_rises; // value mismatch already reported
                if (top_of_frame && !prev_top) begin
                    // R5: lines in the frame just ended follow the previous reload
                    chk("R5 lines", baud_rises, (1 << VWB) - prev_reload);
                    prev_reload = last_fs ? RHI : RLO;
                    baud_rises = 0;
                    frames++;
                end
                prev_top = top_of_frame;
            end
            // choose stimulus for the next edge
            tick     = (cyc % 4) != 3;
            video_en = ((cyc / 200) % 3) != 0;
            if ((cyc % 777) == 0) freq_sel = ~freq_sel;
            // model the edge
            mstep = 0; reloaded = 0;
            if (tick) begin
                if (video_en && (((mh - 2) & 255) >= 32)) begin
                    mcol = (mcol + 1) & 127;
                    mstep = 1;
                end
                if (mh == LAST) begin
                    mh = 0;
                    if (mv == (1 << VWB) - 1) begin
                        mv = freq_sel ? RHI : RLO;
                        mvl = 0; mtop = 1; reloaded = 1;
                    end else begin
                        mv++;
                        mvl = mv & 127;
                    end
                end else begin
                    mh++;
                    if (mh == 4) begin mbaud = 1; baud_rises++; end
                    if (mh == 8) begin mbaud = 0; mtop = 0; end
                end
            end
            last_tick = tick; last_ven = video_en; last_fs = freq_sel;
            @(negedge clk);
        end
        chk("R5 frames seen", frames, 5);
        // reset applied in mid-run
        tick = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule